// File: doc/BRIEF.md
# Interrupt and Exception Control Unit

This unit decides, once per clock, whether the instruction flow of a small 16-bit core is diverted. It watches an active-low level interrupt line and an active-low edge-triggered non-maskable line, and it serves the core's software-trap, trap-return, status-access, EPC-write and wait-for-interrupt operations. It owns the interrupt-disable flag, a 16-bit exception return address and a 2-bit saved status. The arithmetic flag T stays in the core: the unit reads it as an input and asks the core to reload it when it has to.

Whenever the core's execute state machine reports a dispatch boundary, a pending hardware interrupt is accepted in that same cycle. In that one cycle the unit saves the return address and the flags, raises the disable flag, and issues a redirect to the vector. The software trap and the return each issue their own redirect in the cycle they are requested. A level interrupt that arrives while the disable flag is set can still release a core that is waiting, but no handler is entered.

Top module: `irq_exc_ctrl`

## Requirements
- R1: After reset the disable flag reads 1, the return address reads 0x0000, the saved status reads 00, no redirect is issued, no wake is raised and the core is not marked as waiting.
- R2: A 1-to-0 change of `nmi_n` between two consecutive clock samples, seen in a cycle with `disp_rdy` high and no trap or return request, redirects to 0x0002 in that same cycle. Holding `nmi_n` low afterwards causes no second redirect.
- R3: A non-maskable edge that arrives while `disp_rdy` is low is held pending for any number of cycles. It is taken at the first cycle with `disp_rdy` high and no trap or return request.
- R4: With `irq_n` low, the effective disable flag 0, and `disp_rdy` high, the unit redirects to 0x0006 in that cycle. It never does so while the effective disable flag is 1.
- R5: When a non-maskable event and a low `irq_n` coincide at a dispatch boundary, the non-maskable vector 0x0002 wins. The disable flag it sets then masks the level interrupt.
- R6: A hardware entry loads the return address from `ret_pc`, loads the saved status with {effective disable flag, effective T}, and sets the disable flag, all on the same clock edge.
- R7: A software trap with vector field v in 0..2 redirects to (v+1)*2 whatever the disable flag holds. It saves `ret_pc` and {flag, `t_in`} and sets the flag. A vector field of 3 changes nothing and issues no redirect.
- R8: A return redirects to the saved return address, copies saved-status bit 1 into the disable flag, and raises `t_load` with `t_val` equal to saved-status bit 0.
- R9: The status word reads {zeros, saved status[1:0], disable flag, `t_in`}. A status write loads the saved status from bits 3:2 and the disable flag from bit 1, and raises `t_load` with `t_val` equal to bit 0.
- R10: A status write that clears the disable flag at a dispatch boundary, with `irq_n` low, takes the interrupt in the same cycle. A write that sets the flag blocks the interrupt in that cycle.
- R11: After a wait request, `waiting` is 1 until a wake. `wake` rises in any cycle where the core is waiting and a non-maskable event is pending or `irq_n` is low, including when the flag is 1. In that case no redirect occurs.
- R12: An EPC write loads `epc_wdata` into the return address, unless a hardware entry or a software trap in the same cycle saves `ret_pc` instead.
- R13: When requests coincide, the return takes precedence over the software trap, and the trap over a status write. A hardware entry is never taken in a cycle that carries a trap or a return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_n | input | 1 | Level interrupt request, active low |
| nmi_n | input | 1 | Non-maskable request, a falling edge triggers it |
| disp_rdy | input | 1 | Core is at an instruction boundary or idle |
| ret_pc | input | PC_W | Return address to save (next instruction) |
| t_in | input | 1 | Current T flag of the core |
| swi_req | input | 1 | Software trap request |
| swi_vec | input | VEC_W | Software trap vector field |
| reti_req | input | 1 | Return-from-interrupt request |
| sr_wr | input | 1 | Status word write |
| sr_wdata | input | 4 | Status word write value |
| epc_wr | input | 1 | Return address write |
| epc_wdata | input | PC_W | Return address write value |
| wai_req | input | 1 | Wait-for-interrupt request |
| redir_valid | output | 1 | Redirect the program counter this cycle |
| redir_pc | output | PC_W | Redirect target |
| t_load | output | 1 | Core must load T from t_val |
| t_val | output | 1 | T value to load |
| i_flag | output | 1 | Interrupt-disable flag |
| epc | output | PC_W | Saved return address |
| status | output | PC_W | Status word for reads |
| waiting | output | 1 | Core is halted in a wait |
| wake | output | 1 | Release the waiting core |

## Verification
The hardest situations to reach from the ports are the ones where flag changes and interrupt events fall in the same cycle. One is a status write that flips the disable flag while `irq_n` is low and the core is at a dispatch boundary. Another is a non-maskable edge that occurs while the core is busy, followed by a wait of several cycles before the dispatch boundary comes. The directed stimulus builds each of these by holding `disp_rdy` low while the event or the flag change is staged, then raising it in the cycle that matters. After that, a long run of mixed random stimulus is compared cycle by cycle against a behavioural model. That run makes edges, level requests, traps, returns and writes collide in combinations the directed cases do not cover.

// File: rtl/irq_exc_pkg.sv
package irq_exc_pkg;

  // Vector identifiers: the target address is (id + 1) * VEC_STRIDE
  localparam int unsigned VID_NMI    = 0;
  localparam int unsigned VID_SWI    = 1;
  localparam int unsigned VID_IRQ    = 2;
  localparam int unsigned VEC_STRIDE = 2;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_RETI,
    RD_SWI,
    RD_NMI,
    RD_IRQ
  } redir_src_e;

  function automatic int unsigned vec_addr(input int unsigned id);
    return (id + 1) * VEC_STRIDE;
  endfunction

endpackage

// File: rtl/iec_nmi_detect.sv
module iec_nmi_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_n,
  input  logic take_nmi,
  output logic nmi_edge,
  output logic nmi_now
);

  logic prev_q;
  logic pend_q;

  assign nmi_edge = prev_q & ~nmi_n;
  assign nmi_now  = pend_q | nmi_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= nmi_n;
      pend_q <= nmi_now & ~take_nmi;
    end
  end

  // R3: a pending event survives until it is taken
  a_r3_pend_kept: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !take_nmi |=> pend_q);

  // R2: an edge that is not taken at once becomes pending
  a_r2_edge_latched: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_edge && !take_nmi |=> pend_q);

  // R2: a line held low produces no fresh edge
  a_r2_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi_n && take_nmi |=> !nmi_now || nmi_n);

endmodule

// File: rtl/iec_arbiter.sv
module iec_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic disp_rdy,
  input  logic nmi_now,
  input  logic irq_lvl,
  input  logic i_eff,
  input  logic swi_ok,
  input  logic reti_ok,
  input  logic wait_q,
  output logic take_nmi,
  output logic take_irq,
  output logic hw_take,
  output logic wake
);

  logic hw_ok;

  assign hw_ok    = disp_rdy & ~swi_ok & ~reti_ok;
  assign take_nmi = hw_ok & nmi_now;
  assign take_irq = hw_ok & ~nmi_now & irq_lvl & ~i_eff;
  assign hw_take  = take_nmi | take_irq;
  assign wake     = wait_q & (nmi_now | irq_lvl);

  // R5: non-maskable source wins over the level source
  a_r5_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> !nmi_now);

  // R4: the level source is never accepted while masked
  a_r4_masked: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> !i_eff);

  // R13: no hardware entry alongside a trap or a return
  a_r13_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (swi_ok || reti_ok) |-> !hw_take);

  a_r5_single_source: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take_nmi, take_irq}));

endmodule

// File: rtl/iec_state.sv
module iec_state #(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hw_take,
  input  logic            swi_ok,
  input  logic            reti_ok,
  input  logic            sr_ok,
  input  logic            epc_wr,
  input  logic [PC_W-1:0] ret_pc,
  input  logic [PC_W-1:0] epc_wdata,
  input  logic [1:0]      sr_esr,
  input  logic            sr_i,
  input  logic            i_eff,
  input  logic            t_eff,
  input  logic            t_in,
  input  logic            wai_req,
  input  logic            wake,
  output logic            i_q,
  output logic [PC_W-1:0] epc_q,
  output logic [1:0]      esr_q,
  output logic            wait_q
);

  logic save_entry;
  assign save_entry = hw_take | swi_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_q    <= 1'b1;
      esr_q  <= 2'b00;
      epc_q  <= '0;
      wait_q <= 1'b0;
    end else begin
      if (hw_take) begin
        i_q   <= 1'b1;
        esr_q <= {i_eff, t_eff};
      end else if (swi_ok) begin
        i_q   <= 1'b1;
        esr_q <= {i_q, t_in};
      end else if (reti_ok) begin
        i_q   <= esr_q[1];
      end else if (sr_ok) begin
        i_q   <= sr_i;
        esr_q <= sr_esr;
      end

      if (save_entry)  epc_q <= ret_pc;
      else if (epc_wr) epc_q <= epc_wdata;

      wait_q <= wai_req | (wait_q & ~wake);
    end
  end

  // R6: entry saves return address, status, and masks
  a_r6_entry_saves: assert property (@(posedge clk) disable iff (!rst_n)
    hw_take |=> i_q && epc_q == $past(ret_pc) && esr_q == $past({i_eff, t_eff}));

  // R8: return restores the disable flag from saved status
  a_r8_reti_restores: assert property (@(posedge clk) disable iff (!rst_n)
    reti_ok |=> i_q == $past(esr_q[1]));

  // R11: a wake ends the wait unless a new wait is requested
  a_r11_wake_ends_wait: assert property (@(posedge clk) disable iff (!rst_n)
    wake && !wai_req |=> !wait_q);

  // R12: plain EPC write lands
  a_r12_epc_write: assert property (@(posedge clk) disable iff (!rst_n)
    epc_wr && !save_entry |=> epc_q == $past(epc_wdata));

endmodule

// File: rtl/irq_exc_ctrl.sv
module irq_exc_ctrl #(
  parameter int PC_W  = 16,
  parameter int VEC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_n,
  input  logic             nmi_n,
  input  logic             disp_rdy,
  input  logic [PC_W-1:0]  ret_pc,
  input  logic             t_in,
  input  logic             swi_req,
  input  logic [VEC_W-1:0] swi_vec,
  input  logic             reti_req,
  input  logic             sr_wr,
  input  logic [3:0]       sr_wdata,
  input  logic             epc_wr,
  input  logic [PC_W-1:0]  epc_wdata,
  input  logic             wai_req,
  output logic             redir_valid,
  output logic [PC_W-1:0]  redir_pc,
  output logic             t_load,
  output logic             t_val,
  output logic             i_flag,
  output logic [PC_W-1:0]  epc,
  output logic [PC_W-1:0]  status,
  output logic             waiting,
  output logic             wake
);
  import irq_exc_pkg::*;

  localparam logic [VEC_W-1:0] VEC_NOP = '1;
  localparam int STAT_PAD = PC_W - 4;

  // Named internal events
  logic       reti_ok, swi_ok, sr_ok;
  logic       i_eff, t_eff;
  logic       nmi_edge, nmi_now;
  logic       take_nmi, take_irq, hw_take;
  logic       i_q, wait_q;
  logic [1:0] esr_q;
  logic [PC_W-1:0] epc_q;
  redir_src_e src;

  // Request precedence: return, then trap, then status write
  assign reti_ok = reti_req;
  assign swi_ok  = swi_req & (swi_vec != VEC_NOP) & ~reti_req;
  assign sr_ok   = sr_wr & ~reti_ok & ~swi_ok;

  // Flag values as they stand once this cycle's instruction completes
  always_comb begin
    if (reti_ok)     i_eff = esr_q[1];
    else if (swi_ok) i_eff = 1'b1;
    else if (sr_ok)  i_eff = sr_wdata[1];
    else             i_eff = i_q;
  end

  always_comb begin
    if (reti_ok)    t_eff = esr_q[0];
    else if (sr_ok) t_eff = sr_wdata[0];
    else            t_eff = t_in;
  end

  iec_nmi_detect u_nmi (
    .clk      (clk),
    .rst_n    (rst_n),
    .nmi_n    (nmi_n),
    .take_nmi (take_nmi),
    .nmi_edge (nmi_edge),
    .nmi_now  (nmi_now)
  );

  iec_arbiter u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .disp_rdy (disp_rdy),
    .nmi_now  (nmi_now),
    .irq_lvl  (~irq_n),
    .i_eff    (i_eff),
    .swi_ok   (swi_ok),
    .reti_ok  (reti_ok),
    .wait_q   (wait_q),
    .take_nmi (take_nmi),
    .take_irq (take_irq),
    .hw_take  (hw_take),
    .wake     (wake)
  );

  iec_state #(.PC_W(PC_W)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_take   (hw_take),
    .swi_ok    (swi_ok),
    .reti_ok   (reti_ok),
    .sr_ok     (sr_ok),
    .epc_wr    (epc_wr),
    .ret_pc    (ret_pc),
    .epc_wdata (epc_wdata),
    .sr_esr    (sr_wdata[3:2]),
    .sr_i      (sr_wdata[1]),
    .i_eff     (i_eff),
    .t_eff     (t_eff),
    .t_in      (t_in),
    .wai_req   (wai_req),
    .wake      (wake),
    .i_q       (i_q),
    .epc_q     (epc_q),
    .esr_q     (esr_q),
    .wait_q    (wait_q)
  );

  always_comb begin
    if (reti_ok)       src = RD_RETI;
    else if (swi_ok)   src = RD_SWI;
    else if (take_nmi) src = RD_NMI;
    else if (take_irq) src = RD_IRQ;
    else               src = RD_NONE;
  end

  always_comb begin
    unique case (src)
      RD_RETI: redir_pc = epc_q;
      RD_SWI:  redir_pc = PC_W'(vec_addr(32'(swi_vec)));
      RD_NMI:  redir_pc = PC_W'(vec_addr(VID_NMI));
      RD_IRQ:  redir_pc = PC_W'(vec_addr(VID_IRQ));
      default: redir_pc = '0;
    endcase
  end

  assign redir_valid = (src != RD_NONE);
  assign t_load      = reti_ok | sr_ok;
  assign t_val       = t_eff;
  assign i_flag      = i_q;
  assign epc         = epc_q;
  assign status      = {{STAT_PAD{1'b0}}, esr_q, i_q, t_in};
  assign waiting     = wait_q;

  // R7: a trap with the reserved vector field does nothing
  a_r7_vec_nop: assert property (@(posedge clk) disable iff (!rst_n)
    swi_req && swi_vec == VEC_NOP && !reti_req && !disp_rdy |-> !redir_valid);

  // R8: return redirects to the saved address
  a_r8_reti_target: assert property (@(posedge clk) disable iff (!rst_n)
    reti_req |-> redir_valid && redir_pc == epc);

  // R2: an edge at a free dispatch boundary goes to the non-maskable vector
  a_r2_edge_taken: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_edge && disp_rdy && !swi_req && !reti_req |-> redir_valid && redir_pc == PC_W'(2));

  // R11: a masked wake never redirects by itself
  a_r11_masked_wake: assert property (@(posedge clk) disable iff (!rst_n)
    wake && i_q && !nmi_now && !reti_req && !swi_req && !sr_wr |-> !redir_valid);

endmodule

// File: tb/tb_irq_exc_ctrl.sv
module tb_irq_exc_ctrl;
  localparam int PC_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_n = 1'b1, nmi_n = 1'b1, disp_rdy = 1'b0;
  logic [PC_W-1:0] ret_pc = '0;
  logic t_in = 1'b0, swi_req = 1'b0;
  logic [1:0] swi_vec = '0;
  logic reti_req = 1'b0, sr_wr = 1'b0;
  logic [3:0] sr_wdata = '0;
  logic epc_wr = 1'b0;
  logic [PC_W-1:0] epc_wdata = '0;
  logic wai_req = 1'b0;

  logic redir_valid, t_load, t_val, i_flag, waiting, wake;
  logic [PC_W-1:0] redir_pc, epc, status;

  irq_exc_ctrl #(.PC_W(PC_W), .VEC_W(2)) dut (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .nmi_n(nmi_n), .disp_rdy(disp_rdy),
    .ret_pc(ret_pc), .t_in(t_in), .swi_req(swi_req), .swi_vec(swi_vec),
    .reti_req(reti_req), .sr_wr(sr_wr), .sr_wdata(sr_wdata), .epc_wr(epc_wr),
    .epc_wdata(epc_wdata), .wai_req(wai_req), .redir_valid(redir_valid),
    .redir_pc(redir_pc), .t_load(t_load), .t_val(t_val), .i_flag(i_flag),
    .epc(epc), .status(status), .waiting(waiting), .wake(wake)
  );

  always #2 clk = ~clk;  // 250 MHz

  int compared = 0;
  int mismatched = 0;
  string tag = "R1";
  bit done = 0;

  // Reference model state
  bit m_i = 1, m_prev = 1, m_pend = 0, m_wait = 0;
  bit [1:0] m_esr = 0;
  int m_epc = 0;
  // next-state, computed at the falling edge
  bit n_i, n_prev, n_pend, n_wait;
  bit [1:0] n_esr;
  int n_epc;
  bit have_nxt = 0;

  task automatic chk(input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit edge_e, nmi_e, irq_e, swi_e, reti_e, sr_e, i_aft, t_aft, hw, tn, ti, wk;
      bit exp_rv, exp_tl;
      int exp_pc;
      edge_e = m_prev && !nmi_n;
      nmi_e  = m_pend || edge_e;
      irq_e  = !irq_n;
      reti_e = reti_req;
      swi_e  = swi_req && swi_vec != 2'd3 && !reti_e;
      sr_e   = sr_wr && !reti_e && !swi_e;
      i_aft  = reti_e ? m_esr[1] : swi_e ? 1'b1 : sr_e ? sr_wdata[1] : m_i;
      t_aft  = reti_e ? m_esr[0] : sr_e ? sr_wdata[0] : t_in;
      hw     = disp_rdy && !reti_e && !swi_e;
      tn     = hw && nmi_e;
      ti     = hw && !nmi_e && irq_e && !i_aft;
      wk     = m_wait && (nmi_e || irq_e);
      exp_rv = reti_e || swi_e || tn || ti;
      exp_pc = reti_e ? m_epc : swi_e ? (int'(swi_vec) + 1) * 2 : tn ? 2 : ti ? 6 : 0;
      exp_tl = reti_e || sr_e;

      chk("redir_valid", redir_valid, exp_rv);
      if (exp_rv) chk("redir_pc", redir_pc, exp_pc);
      chk("t_load", t_load, exp_tl);
      if (exp_tl) chk("t_val", t_val, t_aft);
      chk("i_flag", i_flag, m_i);
      chk("epc", epc, m_epc);
      chk("status", status, {m_esr, m_i, t_in});
      chk("waiting", waiting, m_wait);
      chk("wake", wake, wk);

      n_i = m_i; n_esr = m_esr; n_epc = m_epc;
      if (tn || ti) begin n_i = 1; n_esr = {i_aft, t_aft}; n_epc = ret_pc; end
      else if (swi_e) begin n_i = 1; n_esr = {m_i, t_in}; n_epc = ret_pc; end
      else begin
        if (reti_e) n_i = m_esr[1];
        else if (sr_e) begin n_i = sr_wdata[1]; n_esr = sr_wdata[3:2]; end
        if (epc_wr) n_epc = epc_wdata;
      end
      n_prev = nmi_n;
      n_pend = nmi_e && !tn;
      n_wait = wai_req || (m_wait && !wk);
      have_nxt = 1;
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_i = 1; m_prev = 1; m_pend = 0; m_wait = 0; m_esr = 0; m_epc = 0; have_nxt = 0;
    end else if (have_nxt) begin
      m_i = n_i; m_prev = n_prev; m_pend = n_pend; m_wait = n_wait;
      m_esr = n_esr; m_epc = n_epc; have_nxt = 0;
    end
  end

  // Advance one clock and drop the one-shot requests
  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      swi_req = 0; reti_req = 0; sr_wr = 0; epc_wr = 0; wai_req = 0;
    end
  endtask

  task automatic run_tests();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tag = "R1"; tick(2);

    tag = "R9"; t_in = 1; sr_wr = 1; sr_wdata = 4'b1010; tick();
    sr_wr = 1; sr_wdata = 4'b0101; tick(); t_in = 0; tick();

    tag = "R12"; epc_wr = 1; epc_wdata = 16'h1234; tick(2);

    tag = "R4"; irq_n = 0; disp_rdy = 0; tick(2);
    ret_pc = 16'h0100; disp_rdy = 1; tick();   // taken here
    tick(2);                                   // masked now
    irq_n = 1; disp_rdy = 0; tick();

    tag = "R8"; reti_req = 1; tick(); tick();

    tag = "R2"; disp_rdy = 1; ret_pc = 16'h0222; nmi_n = 0; tick(); tick(3); nmi_n = 1; tick();

    tag = "R3"; disp_rdy = 0; nmi_n = 0; tick(); nmi_n = 1; tick(4);
    ret_pc = 16'h0330; disp_rdy = 1; tick(); tick();

    tag = "R5"; disp_rdy = 0; sr_wr = 1; sr_wdata = 4'b0000; tick();
    irq_n = 0; nmi_n = 0; disp_rdy = 1; ret_pc = 16'h0440; tick(); tick(2);
    irq_n = 1; nmi_n = 1; disp_rdy = 0; tick();

    tag = "R6_R10"; irq_n = 0; disp_rdy = 1; t_in = 0; ret_pc = 16'h0550;
    sr_wr = 1; sr_wdata = 4'b0001; tick(); tick();
    disp_rdy = 0; irq_n = 1; sr_wr = 1; sr_wdata = 4'b0000; tick();
    irq_n = 0; disp_rdy = 1; sr_wr = 1; sr_wdata = 4'b0010; tick(); tick();
    irq_n = 1; disp_rdy = 0; tick();

    tag = "R7"; ret_pc = 16'h0660; swi_req = 1; swi_vec = 0; tick();
    sr_wr = 1; sr_wdata = 4'b0000; tick();
    swi_req = 1; swi_vec = 1; t_in = 1; ret_pc = 16'h0662; tick();
    swi_req = 1; swi_vec = 2; ret_pc = 16'h0664; tick();
    swi_req = 1; swi_vec = 3; ret_pc = 16'h0666; tick(); t_in = 0; tick();

    tag = "R13"; swi_req = 1; swi_vec = 1; reti_req = 1; tick();
    swi_req = 1; swi_vec = 2; sr_wr = 1; sr_wdata = 4'b1111; tick();
    nmi_n = 0; disp_rdy = 1; reti_req = 1; tick(); tick(); nmi_n = 1; disp_rdy = 0; tick();

    tag = "R11"; sr_wr = 1; sr_wdata = 4'b0010; tick();
    wai_req = 1; tick(); tick(3);
    irq_n = 0; disp_rdy = 1; tick(); irq_n = 1; disp_rdy = 0; tick();
    sr_wr = 1; sr_wdata = 4'b0000; tick();
    wai_req = 1; tick(); tick(2);
    irq_n = 0; disp_rdy = 1; ret_pc = 16'h0770; tick(); irq_n = 1; disp_rdy = 0; tick();
    wai_req = 1; tick(); nmi_n = 0; tick(); nmi_n = 1; disp_rdy = 1; tick(); disp_rdy = 0; tick();

    tag = "R5_mixed";
    for (int c = 0; c < 3000; c++) begin
      int sel;
      irq_n    = ($urandom_range(0, 3) != 0);
      nmi_n    = ($urandom_range(0, 5) != 0);
      disp_rdy = $urandom_range(0, 1);
      t_in     = $urandom_range(0, 1);
      ret_pc   = 16'($urandom);
      sel = $urandom_range(0, 9);
      case (sel)
        0: begin swi_req = 1; swi_vec = 2'($urandom_range(0, 3)); end
        1: reti_req = 1;
        2: begin sr_wr = 1; sr_wdata = 4'($urandom); end
        3: begin epc_wr = 1; epc_wdata = 16'($urandom); end
        4: wai_req = 1;
        5: begin swi_req = 1; swi_vec = 2'($urandom); reti_req = $urandom_range(0, 1);
                  sr_wr = 1; sr_wdata = 4'($urandom); end
        default: ;
      endcase
      tick();
    end
    irq_n = 1; nmi_n = 1; disp_rdy = 0;
    tick(2);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule